// File: doc/BRIEF.md
# Scan-Configured Miniature Logic Fabric

This block is a very small programmable logic fabric. It holds two configurable logic blocks, each a lookup table of eight two-bit words that is addressed by three signals. Each of the two table outputs in a block can be used directly or taken through a flip-flop. Between the two blocks a switch matrix of multiplexers picks, for each of its three outputs, one of four fabric signals: the two outputs of the first block and two primary inputs. The three switch outputs form the address of the second block, and the outputs of the second block are the fabric's outputs.

The fabric holds no configuration registers that software can reach. Every configuration cell is one stage of a single serial chain. The chain advances one bit on each programming clock while the configuration enable is high. While the fabric is being configured, the user flip-flops keep their values and the outputs are held at zero. Normal logic operation resumes when the enable falls.

Top module: `logic_fabric`

## Requirements
- R1: On each rising edge of `cfg_clk` with `cfg_en` high, the chain shifts one place and the value on `cfg_sdi` enters it. Rising edges of `cfg_clk` while `cfg_en` is low leave the configuration unchanged.
- R2: A 42-bit stream, with each field sent most significant bit first, is laid out in this order: table 1 (16 bits, index 15 first), block 1 output modes (2 bits, output 1 first), switch selects for outputs 0, 1 and 2 (2 bits each), table 2 (16 bits), block 2 output modes (2 bits). After all 42 bits are shifted in, the fabric takes on that configuration.
- R3: Table bit index `addr*2+k` gives output k of its block. The address of block 1 is `din[2:0]`, with `din[2]` as the most significant bit.
- R4: A switch select of value v routes fabric signal v to its output. Signals 0 and 1 are the block 1 outputs 0 and 1, signal 2 is `din[3]` and signal 3 is `din[4]`. Switch output j drives bit j of the block 2 address.
- R5: Mode bit 0 passes the table output through combinationally. Mode bit 1 passes the flip-flop copy of that output.
- R6: On each rising `clk` edge with `cfg_en` low and `rst` low, every block flip-flop captures its table output. A registered output therefore lags the matching combinational value by one cycle.
- R7: When `rst` is high at a rising `clk` edge, all block flip-flops clear to 0. Reset takes priority over `cfg_en`.
- R8: While `cfg_en` is high, `dout` is 0 and the block flip-flops keep their values across `clk` edges.
- R9: `dout[k]` is output k of block 2 after its mode multiplexer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous active-high reset of the user flip-flops |
| cfg_clk | input | 1 | Programming clock for the configuration chain |
| cfg_en | input | 1 | Configuration enable: shifts the chain, freezes the flip-flops, forces the outputs to 0 |
| cfg_sdi | input | 1 | Serial configuration data in |
| din | input | 5 | Primary inputs: [2:0] address block 1, [3] and [4] feed the switch matrix |
| dout | output | 2 | Outputs of block 2 |

## Verification
The bench builds the fabric with its default parameters: three address bits, two output bits and four switch inputs. These give a 42-bit chain and five primary inputs, so every input combination can be swept exhaustively under each configuration. Three configurations are used. Between them they cover all four switch sources, a source shared by two switch outputs, and a mix of combinational and registered output modes. This brings within reach the one-cycle lag through a registered first block feeding the second, the freeze during a reload, and reset while registered modes are active.

// File: rtl/fabric_pkg.sv
package fabric_pkg;

  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;

  function automatic int chain_bits(int addr_w, int data_w, int sm_in, int sm_out);
    return 2 * ((1 << addr_w) * data_w + data_w) + sm_out * $clog2(sm_in);
  endfunction

endpackage

// File: rtl/fabric_cfg_chain.sv
module fabric_cfg_chain #(
  parameter int LEN = 42
) (
  input  logic           cfg_clk,
  input  logic           shift_en,
  input  logic           sdi,
  output logic [LEN-1:0] cells
);

  always_ff @(posedge cfg_clk) begin
    if (shift_en) cells <= {cells[LEN-2:0], sdi};
  end

endmodule

// File: rtl/fabric_clb.sv
module fabric_clb import fabric_pkg::*; #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                hold,
  input  logic [(1<<ADDR_W)*DATA_W-1:0]       table_bits,
  input  logic [DATA_W-1:0]                   mode,
  input  logic [ADDR_W-1:0]                   addr,
  output logic [DATA_W-1:0]                   comb_out,
  output logic [DATA_W-1:0]                   ff_q,
  output logic [DATA_W-1:0]                   out
);

  localparam int TBL_BITS = (1 << ADDR_W) * DATA_W;
  localparam int IDX_W    = $clog2(TBL_BITS);

  for (genvar k = 0; k < DATA_W; k++) begin : g_out
    logic [IDX_W-1:0] idx;
    assign idx         = IDX_W'(addr) * IDX_W'(DATA_W) + IDX_W'(k);
    assign comb_out[k] = table_bits[idx];

    always_ff @(posedge clk) begin
      if (rst)        ff_q[k] <= 1'b0;
      else if (!hold) ff_q[k] <= comb_out[k];
    end

    assign out[k] = (out_mode_e'(mode[k]) == OUT_REG) ? ff_q[k] : comb_out[k];
  end

endmodule

// File: rtl/fabric_switch.sv
module fabric_switch #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic [N_OUT*$clog2(N_IN)-1:0] sel_bits,
  input  logic [N_IN-1:0]               src,
  output logic [N_OUT-1:0]              dst
);

  localparam int SEL_W = $clog2(N_IN);

  // select for output 0 sits in the most significant field (sent first)
  for (genvar j = 0; j < N_OUT; j++) begin : g_mux
    logic [SEL_W-1:0] s;
    assign s      = sel_bits[(N_OUT-1-j)*SEL_W +: SEL_W];
    assign dst[j] = src[s];
  end

endmodule

// File: rtl/logic_fabric.sv
module logic_fabric import fabric_pkg::*; #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 2,
  parameter int SM_IN  = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_clk,
  input  logic                             cfg_en,
  input  logic                             cfg_sdi,
  input  logic [ADDR_W+SM_IN-DATA_W-1:0]   din,
  output logic [DATA_W-1:0]                dout
);

  localparam int SM_OUT    = ADDR_W;
  localparam int N_PI      = ADDR_W + SM_IN - DATA_W;
  localparam int SEL_W     = $clog2(SM_IN);
  localparam int TBL_BITS  = (1 << ADDR_W) * DATA_W;
  localparam int CHAIN_LEN = chain_bits(ADDR_W, DATA_W, SM_IN, SM_OUT);
  // field positions in the chain, last-sent field at the bottom
  localparam int MODE2_LO  = 0;
  localparam int TBL2_LO   = MODE2_LO + DATA_W;
  localparam int SEL_LO    = TBL2_LO + TBL_BITS;
  localparam int MODE1_LO  = SEL_LO + SM_OUT * SEL_W;
  localparam int TBL1_LO   = MODE1_LO + DATA_W;

  logic [CHAIN_LEN-1:0] cfg_q;
  logic [DATA_W-1:0]    clb1_comb, clb1_ff, clb1_out;
  logic [DATA_W-1:0]    clb2_comb, clb2_ff, clb2_out;
  logic [SM_IN-1:0]     sw_src;
  logic [SM_OUT-1:0]    sw_dst;

  fabric_cfg_chain #(.LEN(CHAIN_LEN)) u_chain (
    .cfg_clk  (cfg_clk),
    .shift_en (cfg_en),
    .sdi      (cfg_sdi),
    .cells    (cfg_q)
  );

  fabric_clb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_clb1 (
    .clk        (clk),
    .rst        (rst),
    .hold       (cfg_en),
    .table_bits (cfg_q[TBL1_LO +: TBL_BITS]),
    .mode       (cfg_q[MODE1_LO +: DATA_W]),
    .addr       (din[ADDR_W-1:0]),
    .comb_out   (clb1_comb),
    .ff_q       (clb1_ff),
    .out        (clb1_out)
  );

  assign sw_src = {din[N_PI-1:ADDR_W], clb1_out};

  fabric_switch #(.N_IN(SM_IN), .N_OUT(SM_OUT)) u_switch (
    .sel_bits (cfg_q[SEL_LO +: SM_OUT*SEL_W]),
    .src      (sw_src),
    .dst      (sw_dst)
  );

  fabric_clb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_clb2 (
    .clk        (clk),
    .rst        (rst),
    .hold       (cfg_en),
    .table_bits (cfg_q[TBL2_LO +: TBL_BITS]),
    .mode       (cfg_q[MODE2_LO +: DATA_W]),
    .addr       (sw_dst),
    .comb_out   (clb2_comb),
    .ff_q       (clb2_ff),
    .out        (clb2_out)
  );

  assign dout = cfg_en ? '0 : clb2_out;

endmodule

// File: rtl/fabric_chk.sv
module fabric_chk #(
  parameter int LEN    = 42,
  parameter int DATA_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_clk,
  input logic              cfg_en,
  input logic              cfg_sdi,
  input logic [LEN-1:0]    chain,
  input logic [DATA_W-1:0] c1,
  input logic [DATA_W-1:0] f1,
  input logic [DATA_W-1:0] c2,
  input logic [DATA_W-1:0] f2,
  input logic [DATA_W-1:0] dout
);

  a_r1_shift: assert property (@(posedge cfg_clk) disable iff (rst)
    cfg_en |=> chain == {$past(chain[LEN-2:0]), $past(cfg_sdi)});

  a_r1_hold: assert property (@(posedge cfg_clk) disable iff (rst)
    !cfg_en |=> $stable(chain));

  a_r7_clear: assert property (@(posedge clk)
    rst |=> (f1 == '0) && (f2 == '0));

  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (f1 == $past(c1)) && (f2 == $past(c2)));

  a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> $stable(f1) && $stable(f2));

  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> dout == '0);

endmodule

bind logic_fabric fabric_chk #(.LEN(CHAIN_LEN), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfg_clk (cfg_clk),
  .cfg_en  (cfg_en),
  .cfg_sdi (cfg_sdi),
  .chain   (cfg_q),
  .c1      (clb1_comb),
  .f1      (clb1_ff),
  .c2      (clb2_comb),
  .f2      (clb2_ff),
  .dout    (dout)
);

// File: tb/sim_logic_fabric.sv
module sim_logic_fabric;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_clk = 1'b0;
  logic       cfg_en = 1'b1;
  logic       cfg_sdi = 1'b0;
  logic [4:0] din = '0;
  wire  [1:0] dout;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  logic [15:0] tbl1, tbl2;
  logic [1:0]  mode1, mode2;
  int          sel [3];
  logic [1:0]  ff1 = '0, ff2 = '0;

  logic_fabric u0 (
    .clk     (clk),
    .rst     (rst),
    .cfg_clk (cfg_clk),
    .cfg_en  (cfg_en),
    .cfg_sdi (cfg_sdi),
    .din     (din),
    .dout    (dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dout=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input logic [4:0] d, output logic [1:0] c1, output logic [1:0] c2,
                       output logic [1:0] o);
    logic [1:0] o1;
    logic [3:0] m;
    int         a2;
    for (int k = 0; k < 2; k++) begin
      c1[k] = tbl1[int'(d[2:0]) * 2 + k];
      o1[k] = mode1[k] ? ff1[k] : c1[k];
    end
    m  = {d[4], d[3], o1};
    a2 = 4 * int'(m[sel[2]]) + 2 * int'(m[sel[1]]) + int'(m[sel[0]]);
    for (int k = 0; k < 2; k++) begin
      c2[k] = tbl2[a2 * 2 + k];
      o[k]  = mode2[k] ? ff2[k] : c2[k];
    end
    if (cfg_en) o = 2'b00;
  endtask

  task automatic step(input logic [4:0] d, input string tag);
    logic [1:0] c1, c2, o;
    @(negedge clk);
    din = d;
    #1;
    model(d, c1, c2, o);
    check(dout, o, tag);
    @(posedge clk);
    if (rst) begin
      ff1 = '0;
      ff2 = '0;
    end else if (!cfg_en) begin
      ff1 = c1;
      ff2 = c2;
    end
    #1;
  endtask

  task automatic program_fabric();
    bit q[$];
    for (int i = 15; i >= 0; i--) q.push_back(tbl1[i]);
    q.push_back(mode1[1]);
    q.push_back(mode1[0]);
    for (int j = 0; j < 3; j++) begin
      q.push_back(sel[j][1]);
      q.push_back(sel[j][0]);
    end
    for (int i = 15; i >= 0; i--) q.push_back(tbl2[i]);
    q.push_back(mode2[1]);
    q.push_back(mode2[0]);
    cfg_en = 1'b1;
    foreach (q[i]) begin
      cfg_sdi = q[i];
      #2 cfg_clk = 1'b1;
      #2 cfg_clk = 1'b0;
    end
    @(posedge clk);
    #1;
    cfg_en = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < 32; v++) step(5'(v), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tbl1 = '0; tbl2 = '0; mode1 = '0; mode2 = '0;
    sel[0] = 0; sel[1] = 0; sel[2] = 0;
    // reset with configuration enabled: outputs forced low
    step(5'd3, "R7 R8 reset");
    step(5'd5, "R7 R8 reset");
    rst = 1'b0;
    step(5'd7, "R8 config idle");

    // configuration A: all combinational, straight routing
    for (int a = 0; a < 8; a++) begin
      tbl1[a*2]   = (a == 7);
      tbl1[a*2+1] = ^3'(a);
      tbl2[a*2]   = a[2] ^ a[1];
      tbl2[a*2+1] = (a[0] & a[1]) | (a[1] & a[2]) | (a[0] & a[2]);
    end
    mode1 = 2'b00; mode2 = 2'b00;
    sel[0] = 0; sel[1] = 1; sel[2] = 2;
    program_fabric();
    sweep("R2 R3 R4 R9 config A");

    // configuration B: shared source, pin 4 routed twice
    for (int a = 0; a < 8; a++) begin
      tbl1[a*2]   = a[2];
      tbl1[a*2+1] = a[0] | a[1];
      tbl2[a*2]   = ((a * 37 + 5) % 3) == 0;
      tbl2[a*2+1] = (a == 2) || (a == 5) || (a == 6);
    end
    sel[0] = 3; sel[1] = 3; sel[2] = 1;
    program_fabric();
    sweep("R2 R4 config B");

    // configuration C: registered block 1, mixed block 2
    for (int a = 0; a < 8; a++) begin
      tbl1[a*2]   = a[0];
      tbl1[a*2+1] = a[1] & a[2];
      tbl2[a*2]   = a[0];
      tbl2[a*2+1] = a[1] ^ a[2];
    end
    mode1 = 2'b11; mode2 = 2'b10;
    sel[0] = 0; sel[1] = 2; sel[2] = 1;
    program_fabric();
    sweep("R5 R6 config C");
    // explicit lag: din[0] reaches dout[0] one cycle later
    step(5'b00000, "R6 lag");
    step(5'b00001, "R6 lag");
    step(5'b00000, "R6 lag");
    step(5'b01111, "R5 R6 lag");
    step(5'b00110, "R5 R6 lag");

    // programming clock with enable low must not disturb the fabric
    cfg_sdi = 1'b1;
    for (int i = 0; i < 12; i++) begin
      #2 cfg_clk = 1'b1;
      #2 cfg_clk = 1'b0;
    end
    sweep("R1 ignored cfg_clk");

    // freeze during enable, then resume with held state
    step(5'b00111, "R6 load state");
    cfg_en = 1'b1;
    step(5'b00000, "R8 frozen");
    step(5'b00000, "R8 frozen");
    cfg_en = 1'b0;
    step(5'b00000, "R8 held state");
    step(5'b00000, "R8 held state");

    // reset while registered modes are active
    step(5'b11111, "R6 preload");
    rst = 1'b1;
    step(5'b11111, "R7 reset active");
    rst = 1'b0;
    step(5'b00000, "R7 after reset");
    step(5'b00001, "R7 after reset");
    step(5'b01011, "R7 after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule